// File: doc/BRIEF.md
# Flash block lock-state controller

This block keeps a write-protection state for every erase block of a NAND-style flash array. Software programs an inclusive block range through two address registers and then issues one of three commands: unlock, lock or lock-tight. The controller walks the range one block per clock and applies the command to each block in turn. Lock-tight is one-way. Once a block holds it, an unlock or lock walk stops on reaching that block. A lock-tight walk passes over blocks that are currently unlocked and leaves them as they are.

Each block write copies the new state into a write-protection status word. An interrupt flag is raised when a legal command is accepted. An error flag records a walk that reached an index outside the array. A query port reads the state of any block combinationally, so the array can be inspected without a bus. The number of blocks is a parameter, 16 by default. The range registers are `IDX_W = $clog2(NUM_BLK)` bits wide. When the block count is not a power of two, a range can therefore name an index past the last block.

Top module: `flash_lock_ctrl`

## Requirements
- R1: Block states are one-hot 3-bit codes: unlocked 3'b100, locked 3'b010, lock-tight 3'b001. After reset, every block reads locked, `wp_status` reads 3'b010, and `busy`, `irq` and `cmd_err` are low.
- R2: A write strobe on the start register loads both the start and the end register with the low `IDX_W` bits of `wdata`. A write strobe on the end register loads only the end register, masked the same way.
- R3: Command code 8'h23 sets to unlocked every block from start to end inclusive, unless the walk stops early under R5 or R7.
- R4: Command code 8'h2a sets to locked every block from start to end inclusive, unless the walk stops early under R5 or R7.
- R5: During an unlock or lock walk, reaching a lock-tight block ends the walk. That block and every later block keep their state.
- R6: Command code 8'h2c sets to lock-tight every block in the range that is not unlocked. Unlocked blocks are skipped unchanged, and the walk continues.
- R7: When a walk reaches an index equal to or above `NUM_BLK`, it sets `cmd_err` and ends at once.
- R8: Every block write also loads the written state into `wp_status`. `wp_status` changes at no other time, except at reset.
- R9: Acceptance of any of the three codes sets `irq` one clock later. Any other code is ignored entirely.
- R10: `busy` is high while a walk is in progress. A command strobe that arrives while `busy` is high is ignored.
- R11: `status_clr` clears `irq` and `cmd_err`. A set in the same cycle takes precedence.
- R12: A walk visits one block per clock. `busy` stays high for exactly as many cycles as blocks visited, including the block that ends the walk.
- R13: A command accepted with start greater than end sets `irq` but starts no walk and changes no block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_code | input | 8 | Command code |
| start_wr | input | 1 | Write strobe, start block register |
| end_wr | input | 1 | Write strobe, end block register |
| wdata | input | ADDR_W | Register write data |
| status_clr | input | 1 | Clears irq and cmd_err |
| query_idx | input | IDX_W | Block index to inspect |
| query_state | output | 3 | State of block `query_idx` |
| busy | output | 1 | Walk in progress |
| wp_status | output | 3 | State of last block written |
| irq | output | 1 | Command-issued flag |
| cmd_err | output | 1 | Out-of-range walk error |

## Verification
The following results appear one clock after the accepting edge: `irq`, `busy` and the loaded range registers. Each visited block's new state and `wp_status` appear one clock after the cycle that visits it. `cmd_err` follows the out-of-range visit by one clock, and `busy` falls one clock after the last visited block. `query_state` follows `query_idx` within the same cycle. The bench advances a behavioural model on each rising edge using the inputs it drove at the preceding falling edge. It compares every output a quarter period before the next rising edge, when all of these results have settled. Directed checks also count the cycles of each walk and sweep the whole array through the query port.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

    typedef enum logic [2:0] {
        BLK_UNLOCKED = 3'b100,
        BLK_LOCKED   = 3'b010,
        BLK_TIGHT    = 3'b001
    } blk_state_e;

    typedef enum logic [1:0] {
        OP_UNLOCK = 2'd0,
        OP_LOCK   = 2'd1,
        OP_TIGHT  = 2'd2
    } walk_op_e;

    localparam logic [7:0] CODE_UNLOCK = 8'h23;
    localparam logic [7:0] CODE_LOCK   = 8'h2a;
    localparam logic [7:0] CODE_TIGHT  = 8'h2c;

    function automatic logic is_walk_code(input logic [7:0] code);
        return (code == CODE_UNLOCK) || (code == CODE_LOCK) || (code == CODE_TIGHT);
    endfunction

    function automatic walk_op_e code_to_op(input logic [7:0] code);
        walk_op_e op;
        case (code)
            CODE_UNLOCK: op = OP_UNLOCK;
            CODE_TIGHT:  op = OP_TIGHT;
            default:     op = OP_LOCK;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/flash_lock_range_regs.sv
module flash_lock_range_regs #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              end_wr,
    input  logic [ADDR_W-1:0] wdata,
    output logic [IDX_W-1:0]  range_start,
    output logic [IDX_W-1:0]  range_end
);

    typedef struct packed {
        logic [IDX_W-1:0] first;
        logic [IDX_W-1:0] last;
    } range_t;

    range_t rng_d, rng_q;
    logic [IDX_W-1:0] masked;

    assign masked = wdata[IDX_W-1:0];

    always_comb begin
        rng_d = rng_q;
        if (start_wr) begin
            rng_d.first = masked;
            rng_d.last  = masked;
        end else if (end_wr) begin
            rng_d.last = masked;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rng_q <= '0;
        else        rng_q <= rng_d;
    end

    assign range_start = rng_q.first;
    assign range_end   = rng_q.last;

endmodule

// File: rtl/flash_lock_state_array.sv
module flash_lock_state_array
    import flash_lock_pkg::*;
#(
    parameter int NUM_BLK = 16,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  blk_state_e       wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output blk_state_e       rd_val,
    input  logic [IDX_W-1:0] q_idx,
    output blk_state_e       q_val
);

    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_BLK);

    blk_state_e cells [NUM_BLK];

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_cell
        blk_state_e cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (wr_en && (wr_idx == IDX_W'(g))) cell_d = wr_val;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cell_q <= BLK_LOCKED;
            else        cell_q <= cell_d;
        end

        assign cells[g] = cell_q;
    end

    always_comb begin
        rd_val = BLK_LOCKED;
        if ({1'b0, rd_idx} < LIMIT) rd_val = cells[rd_idx];
    end

    always_comb begin
        q_val = BLK_LOCKED;
        if ({1'b0, q_idx} < LIMIT) q_val = cells[q_idx];
    end

endmodule

// File: rtl/flash_lock_walker.sv
module flash_lock_walker
    import flash_lock_pkg::*;
#(
    parameter int NUM_BLK = 16,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    input  logic [IDX_W-1:0] range_start,
    input  logic [IDX_W-1:0] range_end,
    input  logic             status_clr,
    input  blk_state_e       cur_state,
    output logic             busy,
    output logic [IDX_W-1:0] walk_idx,
    output logic             wr_en,
    output blk_state_e       wr_val,
    output blk_state_e       wp_status,
    output logic             irq,
    output logic             cmd_err
);

    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_BLK);

    typedef struct packed {
        logic             busy;
        walk_op_e         op;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        blk_state_e       wp;
        logic             irq;
        logic             err;
    } walk_t;

    walk_t w_d, w_q;
    logic  step, stop;

    always_comb begin
        w_d    = w_q;
        wr_en  = 1'b0;
        wr_val = BLK_LOCKED;
        step   = 1'b0;
        stop   = 1'b0;

        if (status_clr) begin
            w_d.irq = 1'b0;
            w_d.err = 1'b0;
        end

        if (w_q.busy) begin
            if ({1'b0, w_q.idx} >= LIMIT) begin
                w_d.err = 1'b1;
                stop    = 1'b1;
            end else if (w_q.op == OP_TIGHT) begin
                if (cur_state != BLK_UNLOCKED) begin
                    wr_en  = 1'b1;
                    wr_val = BLK_TIGHT;
                end
                step = 1'b1;
            end else if (cur_state == BLK_TIGHT) begin
                stop = 1'b1;
            end else begin
                wr_en  = 1'b1;
                wr_val = (w_q.op == OP_UNLOCK) ? BLK_UNLOCKED : BLK_LOCKED;
                step   = 1'b1;
            end

            if (wr_en) w_d.wp = wr_val;

            if (stop) begin
                w_d.busy = 1'b0;
            end else if (step) begin
                if (w_q.idx == w_q.last) w_d.busy = 1'b0;
                else                     w_d.idx  = w_q.idx + 1'b1;
            end
        end else if (cmd_valid && is_walk_code(cmd_code)) begin
            w_d.irq  = 1'b1;
            w_d.op   = code_to_op(cmd_code);
            w_d.idx  = range_start;
            w_d.last = range_end;
            w_d.busy = (range_start <= range_end);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q      <= '0;
            w_q.op   <= OP_LOCK;
            w_q.wp   <= BLK_LOCKED;
        end else begin
            w_q <= w_d;
        end
    end

    assign busy      = w_q.busy;
    assign walk_idx  = w_q.idx;
    assign wp_status = w_q.wp;
    assign irq       = w_q.irq;
    assign cmd_err   = w_q.err;

endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
    import flash_lock_pkg::*;
#(
    parameter int NUM_BLK = 16,
    parameter int ADDR_W  = 16,
    parameter int IDX_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic              start_wr,
    input  logic              end_wr,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              status_clr,
    input  logic [IDX_W-1:0]  query_idx,
    output logic [2:0]        query_state,
    output logic              busy,
    output logic [2:0]        wp_status,
    output logic              irq,
    output logic              cmd_err
);

    logic [IDX_W-1:0] range_start, range_end, walk_idx;
    logic             wr_en;
    blk_state_e       wr_val, cur_state, q_val, wp_st;

    flash_lock_range_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_range (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_wr   (start_wr),
        .end_wr     (end_wr),
        .wdata      (wdata),
        .range_start(range_start),
        .range_end  (range_end)
    );

    flash_lock_walker #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .range_start(range_start),
        .range_end  (range_end),
        .status_clr (status_clr),
        .cur_state  (cur_state),
        .busy       (busy),
        .walk_idx   (walk_idx),
        .wr_en      (wr_en),
        .wr_val     (wr_val),
        .wp_status  (wp_st),
        .irq        (irq),
        .cmd_err    (cmd_err)
    );

    flash_lock_state_array #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .wr_idx(walk_idx),
        .wr_val(wr_val),
        .rd_idx(walk_idx),
        .rd_val(cur_state),
        .q_idx (query_idx),
        .q_val (q_val)
    );

    assign query_state = q_val;
    assign wp_status   = wp_st;

endmodule

// File: rtl/flash_lock_ctrl_chk.sv
module flash_lock_ctrl_chk #(
    parameter int NUM_BLK = 16,
    parameter int IDX_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [7:0]       cmd_code,
    input logic             status_clr,
    input logic [IDX_W-1:0] query_idx,
    input logic [2:0]       query_state,
    input logic             busy,
    input logic [2:0]       wp_status,
    input logic             irq,
    input logic             cmd_err
);

    localparam int MAX_WALK = 1 << IDX_W;

    logic legal;
    int   busy_cnt;

    assign legal = (cmd_code == 8'h23) || (cmd_code == 8'h2a) || (cmd_code == 8'h2c);

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cnt <= 0;
        else                 busy_cnt <= busy_cnt + 1;
    end

    // R1: block and status codes stay one-hot
    p_wp_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wp_status) == 1);
    p_query_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(query_state) == 1);

    // R9: an accepted legal command raises irq on the next clock
    p_irq_on_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && legal) |=> irq);

    // R10: a walk only begins from an idle cycle with a strobe
    p_walk_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cmd_valid) && !$past(busy)));

    // R7: the error flag only rises out of a walk
    p_err_from_walk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_err) |-> $past(busy));

    // R11: error stays until cleared
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_err && !status_clr) |=> cmd_err);

    // R8: status word moves only during a walk
    p_wp_in_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wp_status) |-> $past(busy));

    // R12: a walk never lasts longer than the index space
    p_walk_bounded_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= MAX_WALK);

endmodule

bind flash_lock_ctrl flash_lock_ctrl_chk #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .status_clr (status_clr),
    .query_idx  (query_idx),
    .query_state(query_state),
    .busy       (busy),
    .wp_status  (wp_status),
    .irq        (irq),
    .cmd_err    (cmd_err)
);

// File: tb/sim_flash_lock_ctrl.sv
module sim_flash_lock_ctrl;

    localparam int NB  = 12;
    localparam int AW  = 16;
    localparam int IW  = 4;
    localparam int UNL = 4;  // 3'b100
    localparam int LCK = 2;  // 3'b010
    localparam int TGT = 1;  // 3'b001

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = 8'h00;
    logic          start_wr = 1'b0;
    logic          end_wr = 1'b0;
    logic [AW-1:0] wdata = '0;
    logic          status_clr = 1'b0;
    logic [IW-1:0] query_idx = '0;
    logic [2:0]    query_state, wp_status;
    logic          busy, irq, cmd_err;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    flash_lock_ctrl #(.NUM_BLK(NB), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .start_wr(start_wr), .end_wr(end_wr), .wdata(wdata), .status_clr(status_clr),
        .query_idx(query_idx), .query_state(query_state), .busy(busy),
        .wp_status(wp_status), .irq(irq), .cmd_err(cmd_err)
    );

    // behavioural reference model
    int m_st [NB];
    int m_wp, m_start, m_end, m_idx, m_last, m_code;
    bit m_busy, m_irq, m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_st[i]) m_st[i] = LCK;
            m_wp = LCK; m_start = 0; m_end = 0; m_idx = 0; m_last = 0; m_code = 0;
            m_busy = 0; m_irq = 0; m_err = 0;
        end else begin
            if (status_clr) begin m_irq = 0; m_err = 0; end
            if (m_busy) begin
                if (m_idx >= NB) begin
                    m_err = 1; m_busy = 0;
                end else if (m_code == 8'h2c) begin
                    if (m_st[m_idx] != UNL) begin m_st[m_idx] = TGT; m_wp = TGT; end
                    if (m_idx == m_last) m_busy = 0; else m_idx++;
                end else if (m_st[m_idx] == TGT) begin
                    m_busy = 0;
                end else begin
                    m_st[m_idx] = (m_code == 8'h23) ? UNL : LCK;
                    m_wp = m_st[m_idx];
                    if (m_idx == m_last) m_busy = 0; else m_idx++;
                end
            end else if (cmd_valid && (cmd_code == 8'h23 || cmd_code == 8'h2a || cmd_code == 8'h2c)) begin
                m_irq = 1; m_code = cmd_code; m_idx = m_start; m_last = m_end;
                m_busy = (m_start <= m_end);
            end
            if (start_wr) begin m_start = wdata % 16; m_end = wdata % 16; end
            else if (end_wr) m_end = wdata % 16;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison a quarter period before the rising edge
    always begin
        @(negedge clk);
        #5;
        if (rst_n) begin
            chk(busy == m_busy, "R10 busy", busy, m_busy);
            chk(int'(wp_status) == m_wp, "R8 wp_status", wp_status, m_wp);
            chk(irq == m_irq, "R9 irq", irq, m_irq);
            chk(cmd_err == m_err, "R7 cmd_err", cmd_err, m_err);
            if (query_idx < NB)
                chk(int'(query_state) == m_st[query_idx], "R3 query_state", query_state, m_st[query_idx]);
        end
    end

    task automatic wr_start(input int v);
        @(negedge clk); start_wr = 1; wdata = AW'(v);
        @(negedge clk); start_wr = 0;
    endtask

    task automatic wr_end(input int v);
        @(negedge clk); end_wr = 1; wdata = AW'(v);
        @(negedge clk); end_wr = 0;
    endtask

    task automatic issue(input logic [7:0] code, output int cycles);
        @(negedge clk); cmd_valid = 1; cmd_code = code;
        @(negedge clk); cmd_valid = 0;
        cycles = 0;
        while (busy && cycles < 100) begin cycles++; @(negedge clk); end
    endtask

    task automatic expect_blk(input int idx, input int exp, input string req);
        @(negedge clk); query_idx = IW'(idx);
        #5;
        chk(int'(query_state) == exp, req, query_state, exp);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #5;
        // R1 reset state
        chk(wp_status == 3'b010, "R1 reset wp", wp_status, 2);
        chk(!busy && !irq && !cmd_err, "R1 reset flags", {busy, irq, cmd_err}, 0);
        for (int i = 0; i < NB; i++) expect_blk(i, LCK, "R1 reset block");

        // R2 masking, R3 unlock 2..5, R12 four cycles
        wr_start(16'h0032);
        wr_end(16'h0125);
        issue(8'h23, cyc);
        chk(cyc == 4, "R12 unlock walk cycles", cyc, 4);
        expect_blk(1, LCK, "R2 below range");
        expect_blk(2, UNL, "R2 start masked");
        expect_blk(5, UNL, "R3 end of range");
        expect_blk(6, LCK, "R2 above range");
        chk(irq == 1, "R9 irq after unlock", irq, 1);

        // R6 lock-tight 1..6 skips unlocked 2..5
        wr_start(1); wr_end(6);
        issue(8'h2c, cyc);
        chk(cyc == 6, "R12 tight walk cycles", cyc, 6);
        expect_blk(1, TGT, "R6 locked becomes tight");
        expect_blk(3, UNL, "R6 unlocked skipped");
        expect_blk(6, TGT, "R6 last tight");
        chk(wp_status == 3'b001, "R8 wp after tight", wp_status, 1);

        // R4/R5 lock 0..3 stops at tight block 1
        wr_start(0); wr_end(3);
        issue(8'h2a, cyc);
        chk(cyc == 2, "R5 stop cycles", cyc, 2);
        expect_blk(1, TGT, "R5 tight kept");
        expect_blk(2, UNL, "R5 later block untouched");
        chk(wp_status == 3'b010, "R4 wp after lock", wp_status, 2);

        // R5 unlock also stops on tight
        wr_start(6); wr_end(7);
        issue(8'h23, cyc);
        expect_blk(6, TGT, "R5 unlock on tight");
        expect_blk(7, LCK, "R5 unlock stopped");

        // R7 out of range 10..15
        wr_start(10); wr_end(15);
        issue(8'h23, cyc);
        chk(cyc == 3, "R7 walk cycles", cyc, 3);
        chk(cmd_err == 1, "R7 error set", cmd_err, 1);
        expect_blk(11, UNL, "R7 in-range part done");

        // R11 clear
        @(negedge clk); status_clr = 1;
        @(negedge clk); status_clr = 0; #5;
        chk(!irq && !cmd_err, "R11 cleared", {irq, cmd_err}, 0);

        // R10 command while busy ignored
        wr_start(7); wr_end(9);
        @(negedge clk); cmd_valid = 1; cmd_code = 8'h23;
        @(negedge clk); cmd_code = 8'h2a;
        @(negedge clk); cmd_valid = 0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        expect_blk(8, UNL, "R10 busy strobe ignored");
        expect_blk(9, UNL, "R10 busy strobe ignored end");

        // R4 plain lock 7..8
        wr_start(7); wr_end(8);
        issue(8'h2a, cyc);
        expect_blk(7, LCK, "R4 lock");
        expect_blk(9, UNL, "R4 outside untouched");

        // R13 start > end
        @(negedge clk); status_clr = 1;
        @(negedge clk); status_clr = 0;
        wr_start(8); wr_end(3);
        issue(8'h2a, cyc);
        chk(cyc == 0, "R13 no walk", cyc, 0);
        chk(irq == 1, "R13 irq", irq, 1);
        expect_blk(3, UNL, "R13 unchanged");

        // R9 illegal code ignored
        @(negedge clk); status_clr = 1;
        @(negedge clk); status_clr = 0;
        wr_start(0); wr_end(11);
        issue(8'h55, cyc);
        chk(irq == 0 && cyc == 0, "R9 illegal code", irq, 0);
        expect_blk(0, LCK, "R9 illegal no change");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule